// File: doc/BRIEF.md
# Third-Order Sinc Decimation Filter

This block turns the multi-level output of a second-order delta-sigma modulator into signed PCM words. Each modulator-clock cycle it receives a 4-bit comparator word. The number of ones in that word sets a signed level from -2 to +2. Three cascaded integrators run at the modulator rate. Once per oversampling period, three comb stages take differences of the integrator output. The result is normalised, so full scale is the same for every oversampling ratio, clamped, and presented as a left-justified two's-complement word with a one-cycle strobe.

A sinc³ response needs three full output periods of input before a result is correct. The block therefore tracks how many results it has produced since the last restart, and marks every result as settled or not. A restart is a conversion reset, a hard reset or any change to the ratio or width setting. When `hold_unsettled_i` is set, unsettled results are dropped and never strobed, so a downstream consumer (a data-ready interrupt, for example) only ever sees correct data. While the conversion reset is held, the input word is disregarded. The filter behaves as if it saw the mid-scale comparator word 0011, and all accumulated data is cleared.

Top module: `sinc3_decimator`

## Requirements
- R1: The input level is the count of ones in `therm_i` minus 2, whatever the bit order: 0000 gives -2, 0001 gives -1, 0011 gives 0, 0111 gives +1 and 1111 gives +2. A word such as 0110 counts as 0.
- R2: In 24-bit mode, a settled result equals the mean input level over the filter window times 2^22, as a 24-bit two's-complement word: +1 gives 0x400000, -1 gives 0xC00000, +0.5 gives 0x200000, +1.5 gives 0x600000 and 0 gives 0x000000.
- R3: `osr_sel_i` values 0, 1, 2 and 3 select 32, 64, 128 and 256 input cycles per result. `valid_o` is a one-cycle pulse, at most one per period. After a restart the strobes fall a whole number of periods after the restart cycle.
- R4: When `wide_i` = 1 the full 24-bit result is output. When `wide_i` = 0 the result is reduced to 16 bits, kept MSB-aligned in `sample_o[23:8]`, and `sample_o[7:0]` is zero.
- R5: Results saturate instead of wrapping. A mean of +2 gives 0x7FFFFF (0x7FFF00 in 16-bit mode) and a mean of -2 gives 0x800000.
- R6: The first two results after a restart carry `settled_o` = 0. The third and every later result carry `settled_o` = 1, and the third already equals the steady value.
- R7: With `hold_unsettled_i` = 1, unsettled results raise no strobe and leave `sample_o` unchanged. The first strobe after a restart is then the third result.
- R8: A cycle with `conv_rst_i` = 1, or with `osr_sel_i` or `wide_i` different from the previous cycle, is a restart. It clears the filter state, the decimation phase and the settling count. In the next cycle `sample_o` = 0, `valid_o` = 0 and `settled_o` = 0.
- R9: While `rst` is high, `sample_o` = 0, `valid_o` = 0 and `settled_o` = 0.
- R10: While `conv_rst_i` is held, `therm_i` has no effect. After release, even the unsettled results for a zero-level input are exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst | input | 1 | Synchronous active-high hard reset |
| conv_rst_i | input | 1 | Conversion reset; clears filter data while high |
| therm_i | input | 4 | Comparator word from the 5-level quantizer |
| osr_sel_i | input | 2 | Oversampling ratio select (32/64/128/256) |
| wide_i | input | 1 | 1 = 24-bit result, 0 = 16-bit MSB-justified result |
| hold_unsettled_i | input | 1 | 1 = suppress strobes for unsettled results |
| sample_o | output | 24 | Decimated two's-complement result |
| valid_o | output | 1 | One-cycle strobe for a new result |
| settled_o | output | 1 | The current result comes from a fully settled filter |

## Verification
The bound checker assumes two things about the inputs. First, `hold_unsettled_i` changes only together with a restart. Second, `osr_sel_i` and `wide_i` are held constant between restarts, so the ratio read at each strobe is the one in force during that period. The stimulus keeps within these limits. Every segment sets the ratio, width and hold mode in one cycle and either pulses the conversion reset or changes the configuration. Between restarts it only varies the comparator word, using constant codes and short periodic patterns whose mean over any window of 32 or more cycles is exact, so every settled result has one closed-form expected value.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    // Quantizer word and signed level widths
    localparam int unsigned THERM_W    = 4;
    localparam int unsigned LEVEL_W    = 3;
    // Filter order and ratio selection
    localparam int unsigned ORDER      = 3;
    localparam int unsigned SEL_W      = 2;
    localparam int unsigned OSR_MIN_LG = 5;
    localparam int unsigned OSR_MAX_LG = OSR_MIN_LG + (1 << SEL_W) - 1;
    // Accumulator wide enough for the largest ratio
    localparam int unsigned ACC_W      = ORDER * OSR_MAX_LG + LEVEL_W;
    // Output formats
    localparam int unsigned OUT_W      = 24;
    localparam int unsigned NARROW_W   = 16;
    // Results discarded after a restart
    localparam int unsigned SETTLE_N   = ORDER - 1;
    localparam int unsigned SETTLE_W   = $clog2(SETTLE_N + 1);

    typedef logic signed [ACC_W-1:0]   acc_t;
    typedef logic signed [LEVEL_W-1:0] level_t;
    typedef logic [OUT_W-1:0]          word_t;

    typedef struct packed {
        logic [SEL_W-1:0] osr;
        logic             wide;
    } cfg_t;

    typedef struct packed {
        word_t data;
        logic  settled;
    } result_t;

    // Signed level = ones in the comparator word minus the mid count
    function automatic level_t therm_level(input logic [THERM_W-1:0] t);
        logic [LEVEL_W-1:0] ones;
        ones = '0;
        for (int i = 0; i < THERM_W; i++) begin
            ones = ones + LEVEL_W'(t[i]);
        end
        return $signed(ones - LEVEL_W'(THERM_W / 2));
    endfunction

    function automatic int unsigned osr_log2(input logic [SEL_W-1:0] sel);
        return OSR_MIN_LG + int'(sel);
    endfunction

endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
    parameter int unsigned W      = 27,
    parameter int unsigned IN_W   = 3,
    parameter int unsigned STAGES = 3
) (
    input  logic                   clk,
    input  logic                   clear,
    input  logic signed [IN_W-1:0] din,
    output logic signed [W-1:0]    sum_o
);

    logic signed [W-1:0] acc_q [STAGES];
    logic signed [W-1:0] acc_d [STAGES];

    // Each stage adds the new value of the stage before it, so the last
    // stage reflects the current input in the same cycle.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign acc_d[g] = acc_q[g] + {{(W-IN_W){din[IN_W-1]}}, din};
        end else begin : g_tail
            assign acc_d[g] = acc_q[g] + acc_d[g-1];
        end

        always_ff @(posedge clk) begin
            if (clear) begin
                acc_q[g] <= '0;
            end else begin
                acc_q[g] <= acc_d[g];
            end
        end
    end

    assign sum_o = acc_d[STAGES-1];

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
    parameter int unsigned W      = 27,
    parameter int unsigned STAGES = 3
) (
    input  logic                clk,
    input  logic                clear,
    input  logic                dec,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);

    logic signed [W-1:0] dly_q [STAGES];
    logic signed [W-1:0] diff  [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign diff[g] = din - dly_q[g];
            always_ff @(posedge clk) begin
                if (clear) begin
                    dly_q[g] <= '0;
                end else if (dec) begin
                    dly_q[g] <= din;
                end
            end
        end else begin : g_tail
            assign diff[g] = diff[g-1] - dly_q[g];
            always_ff @(posedge clk) begin
                if (clear) begin
                    dly_q[g] <= '0;
                end else if (dec) begin
                    dly_q[g] <= diff[g-1];
                end
            end
        end
    end

    assign dout = diff[STAGES-1];

endmodule

// File: rtl/sinc3_format.sv
module sinc3_format
    import sinc3_pkg::*;
#(
    parameter int unsigned AW      = ACC_W,
    parameter int unsigned OW      = OUT_W,
    parameter int unsigned NW      = NARROW_W,
    parameter int unsigned MAX_LG  = OSR_MAX_LG,
    parameter int unsigned MIN_LG  = OSR_MIN_LG,
    parameter int unsigned N_ORDER = ORDER
) (
    input  logic signed [AW-1:0] acc_i,
    input  logic [SEL_W-1:0]     osr_i,
    input  logic                 wide_i,
    output logic [OW-1:0]        word_o
);

    // Full scale after normalisation is 2^(ORDER*MAX_LG + 1)
    localparam int unsigned DROP = N_ORDER * MAX_LG + 1 - (OW - 1);
    localparam logic signed [AW-1:0] POS_LIM = AW'((64'sd1 <<< (OW - 1)) - 64'sd1);
    localparam logic signed [AW-1:0] NEG_LIM = -POS_LIM - AW'(1);
    localparam logic [OW-1:0] LO_MASK = OW'((64'd1 << (OW - NW)) - 64'd1);

    int unsigned         lift;
    logic signed [AW-1:0] norm;
    logic signed [AW-1:0] scaled;
    logic [OW-1:0]        clamped;

    always_comb begin
        lift   = N_ORDER * (MAX_LG - (MIN_LG + int'(osr_i)));
        norm   = acc_i <<< lift;
        scaled = norm >>> DROP;
        if (scaled > POS_LIM) begin
            clamped = POS_LIM[OW-1:0];
        end else if (scaled < NEG_LIM) begin
            clamped = NEG_LIM[OW-1:0];
        end else begin
            clamped = scaled[OW-1:0];
        end
        word_o = wide_i ? clamped : (clamped & ~LO_MASK);
    end

endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
    import sinc3_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               conv_rst_i,
    input  logic [THERM_W-1:0] therm_i,
    input  logic [SEL_W-1:0]   osr_sel_i,
    input  logic               wide_i,
    input  logic               hold_unsettled_i,
    output logic [OUT_W-1:0]   sample_o,
    output logic               valid_o,
    output logic               settled_o
);

    localparam int unsigned CNT_W = OSR_MAX_LG;

    cfg_t                cfg_now, cfg_q;
    logic                restart, clear;
    level_t              level;
    logic [CNT_W-1:0]    phase_q, last_idx;
    logic                dec;
    acc_t                integ_sum, comb_out;
    word_t               word;
    logic [SETTLE_W-1:0] done_q;
    logic                is_settled, emit;
    result_t             res_q;
    logic                valid_q;

    assign cfg_now = '{osr: osr_sel_i, wide: wide_i};

    always_ff @(posedge clk) begin
        cfg_q <= cfg_now;
    end

    assign restart = conv_rst_i || (cfg_now != cfg_q);
    assign clear   = rst || restart;
    assign level   = therm_level(therm_i);

    // Decimation phase
    assign last_idx = CNT_W'((1 << osr_log2(osr_sel_i)) - 1);
    assign dec      = !clear && (phase_q == last_idx);

    always_ff @(posedge clk) begin
        if (clear) begin
            phase_q <= '0;
        end else if (dec) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + CNT_W'(1);
        end
    end

    sinc3_integ #(.W(ACC_W), .IN_W(LEVEL_W), .STAGES(ORDER)) u_integ (
        .clk   (clk),
        .clear (clear),
        .din   (level),
        .sum_o (integ_sum)
    );

    sinc3_comb #(.W(ACC_W), .STAGES(ORDER)) u_comb (
        .clk   (clk),
        .clear (clear),
        .dec   (dec),
        .din   (integ_sum),
        .dout  (comb_out)
    );

    sinc3_format u_fmt (
        .acc_i  (comb_out),
        .osr_i  (osr_sel_i),
        .wide_i (wide_i),
        .word_o (word)
    );

    // Settling count: results produced since the last restart
    assign is_settled = (done_q == SETTLE_W'(SETTLE_N));
    assign emit       = dec && (is_settled || !hold_unsettled_i);

    always_ff @(posedge clk) begin
        if (clear) begin
            done_q <= '0;
        end else if (dec && !is_settled) begin
            done_q <= done_q + SETTLE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (clear) begin
            res_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= emit;
            if (emit) begin
                res_q <= '{data: word, settled: is_settled};
            end
        end
    end

    assign sample_o  = res_q.data;
    assign settled_o = res_q.settled;
    assign valid_o   = valid_q;

endmodule

// File: rtl/sinc3_decimator_chk.sv
module sinc3_decimator_chk
    import sinc3_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               conv_rst_i,
    input logic [SEL_W-1:0]   osr_sel_i,
    input logic               wide_i,
    input logic               hold_unsettled_i,
    input logic [OUT_W-1:0]   sample_o,
    input logic               valid_o,
    input logic               settled_o
);

    logic [SEL_W:0] cfg_seen;
    logic           restart_c;
    logic [15:0]    gap;
    logic [15:0]    period;
    logic [1:0]     nvalid;

    always_ff @(posedge clk) begin
        cfg_seen <= {osr_sel_i, wide_i};
    end

    assign restart_c = conv_rst_i || ({osr_sel_i, wide_i} != cfg_seen);
    assign period    = 16'(1 << (OSR_MIN_LG + int'(osr_sel_i)));

    always_ff @(posedge clk) begin
        if (rst || restart_c) begin
            gap    <= '0;
            nvalid <= '0;
        end else begin
            gap <= valid_o ? 16'd1 : gap + 16'd1;
            if (valid_o && nvalid != 2'd2) begin
                nvalid <= nvalid + 2'd1;
            end
        end
    end

    // R3
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (gap != 16'd0) && ((gap & (period - 16'd1)) == 16'd0));

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R4
    narrow_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !$past(wide_i)) |-> (sample_o[7:0] == 8'h00));

    // R6
    early_unsettled_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !settled_o) |-> (nvalid < 2'd2));

    // R6
    late_settled_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && nvalid == 2'd2) |-> settled_o);

    // R7
    hold_blocks_unsettled_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !settled_o) |-> !$past(hold_unsettled_i));

    // R7
    sample_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && !$past(restart_c) && !$past(rst)) |-> $stable(sample_o));

    // R8
    restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(restart_c) |-> (!valid_o && !settled_o && sample_o == '0));

    // R9
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!valid_o && !settled_o && sample_o == '0));

endmodule

bind sinc3_decimator sinc3_decimator_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .conv_rst_i       (conv_rst_i),
    .osr_sel_i        (osr_sel_i),
    .wide_i           (wide_i),
    .hold_unsettled_i (hold_unsettled_i),
    .sample_o         (sample_o),
    .valid_o          (valid_o),
    .settled_o        (settled_o)
);

// File: tb/sinc3_decimator_test.sv
module sinc3_decimator_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_rst = 1'b0;
    logic [3:0]  therm;
    logic [1:0]  osr_sel = 2'd1;
    logic        wide = 1'b1;
    logic        hold = 1'b0;
    logic [23:0] sample;
    logic        valid;
    logic        settled;

    int pat = 0;
    int ph  = 0;
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [23:0] data;
        bit          settled;
        bit          care;
        string       rq;
    } exp_t;

    exp_t sb[$];
    exp_t cur;

    always #10 clk = ~clk;

    sinc3_decimator uut (
        .clk              (clk),
        .rst              (rst),
        .conv_rst_i       (conv_rst),
        .therm_i          (therm),
        .osr_sel_i        (osr_sel),
        .wide_i           (wide),
        .hold_unsettled_i (hold),
        .sample_o         (sample),
        .valid_o          (valid),
        .settled_o        (settled)
    );

    // Comparator words for each stimulus pattern (R1 level = ones - 2)
    function automatic logic [3:0] pat_code(int p, int k);
        case (p)
            0: return 4'b0011;
            1: return 4'b0111;
            2: return 4'b1111;
            3: return 4'b0001;
            4: return 4'b0000;
            5: return k[0] ? 4'b0000 : 4'b1111;
            6: return k[0] ? 4'b0111 : 4'b1111;
            7: case (k % 4)
                   0: return 4'b1111;
                   1: return 4'b0110;
                   2: return 4'b1110;
                   default: return 4'b0001;
               endcase
            default: return 4'b0011;
        endcase
    endfunction

    // Mean level in quarters, scaled by 2^22 and clamped (R2, R4, R5)
    function automatic logic [23:0] exp_word(int p, logic w);
        int     q;
        longint v;
        logic [23:0] r;
        case (p)
            1: q = 4;
            2: q = 8;
            3: q = -4;
            4: q = -8;
            6: q = 6;
            7: q = 2;
            default: q = 0;
        endcase
        v = longint'(q) * (longint'(1) << 20);
        if (v > 64'sd8388607) v = 64'sd8388607;
        r = v[23:0];
        if (!w) r[7:0] = 8'h00;
        return r;
    endfunction

    assign therm = pat_code(pat, ph);

    always @(posedge clk) begin
        ph  <= ph + 1;
        cyc <= cyc + 1;
    end

    // Monitor: pop one expected item per strobe
    always @(negedge clk) begin
        if (!rst && valid && !done) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R3: unexpected strobe, got %h expected none", sample);
            end else begin
                cur = sb.pop_front();
                if (settled !== cur.settled) begin
                    fails++;
                    $display("FAIL R6/R7 (%s): settled flag got %0b expected %0b",
                             cur.rq, settled, cur.settled);
                end else if (cur.care && sample !== cur.data) begin
                    fails++;
                    $display("FAIL %s: sample got %h expected %h", cur.rq, sample, cur.data);
                end
            end
        end
    end

    task automatic check(input bit ok, input string rq, input logic [23:0] got, input logic [23:0] want);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", rq, got, want);
        end
    endtask

    // Driver: configure, restart, push expected results, let the stream run
    task automatic run_seg(input logic [1:0] o, input logic w, input logic h, input int p,
                           input int nout, input int rst_cyc, input int pre_p, input string rq);
        int n;
        n = 1 << (5 + int'(o));
        @(negedge clk);
        osr_sel  = o;
        wide     = w;
        hold     = h;
        pat      = (rst_cyc > 0) ? pre_p : p;
        conv_rst = (rst_cyc > 0);
        for (int j = 1; j <= nout; j++) begin
            bit st;
            st = (j >= 3);
            if (h && !st) continue;
            sb.push_back('{data: exp_word(p, w), settled: st, care: (st || p == 0), rq: rq});
        end
        if (rst_cyc > 1) repeat (rst_cyc - 1) @(negedge clk);
        @(negedge clk);
        // R8: restart clears the result registers in the next cycle
        check(sample == 24'h0 && !valid && !settled, "R8", sample, 24'h0);
        conv_rst = 1'b0;
        pat      = p;
        repeat (nout * n + 10) @(negedge clk);
        // R3: exactly the expected number of strobes appeared
        check(sb.size() == 0, "R3", 24'(sb.size()), 24'h0);
        sb.delete();
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, got %0d cycles expected under 150000", cyc);
            finish_up();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R9: reset state
        check(sample == 24'h0 && !valid && !settled, "R9", sample, 24'h0);
        rst = 1'b0;

        run_seg(2'd1, 1'b1, 1'b0, 1, 5, 1,  0, "R2");      // +1, ratio 64
        run_seg(2'd0, 1'b1, 1'b0, 2, 5, 0,  0, "R5");      // +2 clamps, config change restart
        run_seg(2'd0, 1'b1, 1'b0, 4, 4, 1,  0, "R5");      // -2 full negative
        run_seg(2'd2, 1'b0, 1'b0, 3, 4, 1,  0, "R4");      // -1, 16-bit, ratio 128
        run_seg(2'd2, 1'b0, 1'b0, 2, 4, 1,  0, "R4_R5");   // +2 clamps in 16-bit
        run_seg(2'd3, 1'b1, 1'b0, 6, 4, 1,  0, "R1_R3");   // +2/+1 alternating, ratio 256
        run_seg(2'd1, 1'b1, 1'b1, 7, 5, 1,  0, "R1_R7");   // mixed codes, hold mode
        run_seg(2'd1, 1'b1, 1'b0, 5, 4, 1,  0, "R1");      // +2/-2 alternating
        run_seg(2'd1, 1'b1, 1'b0, 0, 4, 40, 2, "R10");     // full code ignored in reset
        run_seg(2'd0, 1'b1, 1'b0, 1, 5, 0,  0, "R8");      // ratio change restarts

        finish_up();
    end

endmodule